// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a software watchdog for a system-integration unit. While enabled it counts a period chosen by a 2-bit select from four power-of-two lengths. Software keeps the count from expiring by writing a two-byte key to a service register. The key is an arming byte followed later by a firing byte, and any other accesses may come between the two. If the count expires first, the block raises an interrupt request. That request stays pending until the processor runs an interrupt-acknowledge cycle, during which the block drives a programmable 8-bit vector.

If software enables escalation and the interrupt is still unacknowledged one full period after it was raised, the block emits a one-cycle forced transfer acknowledge. This lets a stalled bus cycle end so that the acknowledge can happen. A sticky status bit records the event until software clears it.

The register port is byte wide and offers three registers. Offset 0x1 is control/status: bit 1 enables escalation and bit 0 is the sticky flag. Offset 0x2 is the vector. Offset 0x3 is the service register. The reset input is asynchronous active-low and is expected to be released synchronously by the reset tree.

Top module: `wdog_svc_timer`

## Requirements
- R1: After reset, irq and xfer_ack are 0, the vector register (offset 0x2) reads 0x0F, and the control/status register (offset 0x1) reads 0x00.
- R2: With run_en high and no service, irq rises after exactly 2^(4+2*tmo_sel) clock edges counted from reset or from the last restart (16, 64, 256 or 1024 edges).
- R3: A supervisor write of 0x55 to offset 0x3 arms the key. A later supervisor write of 0xAA to offset 0x3 restarts the count, so a full period must pass before a timeout. Other accesses between the two writes, including writes of other values to offset 0x3, do not break the key.
- R4: A write of 0xAA to offset 0x3 with no arming 0x55 since the last restart or timeout has no effect on the count. A timeout disarms the key.
- R5: Once irq is set, key writes do not clear it. irq clears on the edge where iack is high.
- R6: While iack is high, iack_vec equals the value of the vector register, which is written at offset 0x2. While iack is low, iack_vec is 0x00.
- R7: Writes with reg_sup low change no register and do not advance the key.
- R8: With escalation enabled (bit 1 of offset 0x1) and irq still pending, a further full period asserts xfer_ack for exactly one cycle and sets the sticky flag (bit 0 of offset 0x1).
- R9: Writing 1 to bit 0 of offset 0x1 clears the sticky flag. Writing 0 to that bit leaves it unchanged.
- R10: While run_en is low the count holds its value, and it resumes from that value when run_en returns high.
- R11: An acknowledge of a pending irq restarts the count, so the next timeout and the next escalation are each a full period away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| tmo_sel | input | 2 | Timeout period select |
| reg_wr | input | 1 | Register write strobe |
| reg_sup | input | 1 | Supervisor qualifier for writes |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Pending watchdog interrupt |
| iack | input | 1 | Interrupt-acknowledge strobe |
| iack_vec | output | 8 | Vector driven during acknowledge |
| xfer_ack | output | 1 | Forced transfer acknowledge pulse |

## Verification
The hardest state to reach is escalation. It needs a timeout, then a full second period with no acknowledge, with escalation already enabled. After that, the sticky flag must be cleared and a restart by acknowledge must be shown to push both the timeout and the escalation a full period away again. Directed sequences count the edges exactly with the shortest period to reach these cases. A seeded random phase then mixes key bytes, stray writes, user-mode writes, acknowledges and period changes against a cycle model in the bench, which reaches escalations while the key is half armed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h1;
  localparam logic [REG_AW-1:0] OFS_VEC  = 4'h2;
  localparam logic [REG_AW-1:0] OFS_SVC  = 4'h3;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [7:0] VEC_RST  = 8'h0F;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_wr,
  input  logic [7:0] wdata,
  input  logic       tick,
  input  logic       blocked,
  output logic       svc_done
);
  logic armed_q, armed_d;
  logic key_hit;

  assign key_hit  = svc_wr && (wdata == KEY_FIRE) && armed_q;
  assign svc_done = key_hit && !blocked;

  always_comb begin
    armed_d = armed_q;
    if (tick)                             armed_d = 1'b0;
    else if (svc_wr && wdata == KEY_ARM)  armed_d = 1'b1;
    else if (key_hit)                     armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R3: an armed key survives unrelated cycles
  a_r3_arm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !svc_wr && !tick |=> armed_q);
  // R4: a timeout disarms the key
  a_r4_tick_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !armed_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_LOG2 = 4,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);
  localparam logic [CNT_W:0] ONE = 1;

  logic [CNT_W-1:0] lim_tab [NSEL];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((ONE << (BASE_LOG2 + STEP_LOG2 * g)) - 1'b1);
  end

  assign at_end = (cnt_q >= lim_tab[sel]);
  assign tick   = run && !restart && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (run)    cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: count frozen while disabled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !restart |=> $stable(cnt_q));
  // R11: restart returns the count to zero
  a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sup,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              esc_fire,
  output logic [7:0]        vec_q,
  output logic              esc_en,
  output logic [7:0]        reg_rdata
);
  logic       wr_ok;
  logic [7:0] vec_d;
  logic       esc_d, sticky_q, sticky_d;

  assign wr_ok = reg_wr && reg_sup;

  always_comb begin
    vec_d    = vec_q;
    esc_d    = esc_en;
    sticky_d = sticky_q;
    if (wr_ok && reg_addr == OFS_VEC)  vec_d = reg_wdata;
    if (wr_ok && reg_addr == OFS_CTRL) begin
      esc_d = reg_wdata[1];
      if (reg_wdata[0]) sticky_d = 1'b0;
    end
    if (esc_fire) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q    <= VEC_RST;
      esc_en   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      vec_q    <= vec_d;
      esc_en   <= esc_d;
      sticky_q <= sticky_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = {6'd0, esc_en, sticky_q};
      OFS_VEC:  reg_rdata = vec_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  // R7: user-mode writes leave the registers alone
  a_r7_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_sup && !esc_fire |=> $stable(vec_q) && $stable(esc_en) && $stable(sticky_q));
  // R8: escalation records itself
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    esc_fire |=> sticky_q);
endmodule

// File: rtl/wdog_svc_timer.sv
module wdog_svc_timer
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [SEL_W-1:0]  tmo_sel,
  input  logic              reg_wr,
  input  logic              reg_sup,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              iack,
  output logic [7:0]        iack_vec,
  output logic              xfer_ack
);
  logic pend_q, pend_d, xack_q;
  logic tick, svc_done, restart, ack_take, esc_fire, esc_en, svc_wr;
  logic [7:0] vec_q;

  assign svc_wr   = reg_wr && reg_sup && (reg_addr == OFS_SVC);
  assign ack_take = iack && pend_q;
  assign restart  = svc_done || ack_take;
  assign esc_fire = tick && pend_q && esc_en;

  wdog_key_seq u_key (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wdata(reg_wdata),
    .tick(tick), .blocked(pend_q), .svc_done(svc_done)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en), .restart(restart),
    .sel(tmo_sel), .tick(tick)
  );

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sup(reg_sup),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .esc_fire(esc_fire),
    .vec_q(vec_q), .esc_en(esc_en), .reg_rdata(reg_rdata)
  );

  always_comb begin
    pend_d = pend_q;
    if (ack_take)  pend_d = 1'b0;
    else if (tick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      xack_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      xack_q <= esc_fire;
    end
  end

  assign irq      = pend_q;
  assign xfer_ack = xack_q;
  assign iack_vec = iack ? vec_q : 8'h00;

  // R5: pending request survives everything except an acknowledge
  a_r5_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !iack |=> irq);
  a_r5_iack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    iack && irq |=> !irq);
  // R8: forced acknowledge is a lone pulse tied to a pending request
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);
  a_r8_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_ack) |-> $past(irq));
endmodule

// File: tb/sim_wdog_svc_timer.sv
module sim_wdog_svc_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 1'b0, reg_wr = 1'b0, reg_sup = 1'b0, iack = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata, iack_vec;
  logic irq, xfer_ack;
  int errs = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;

  wdog_svc_timer u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tmo_sel(tmo_sel),
    .reg_wr(reg_wr), .reg_sup(reg_sup), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .iack(iack), .iack_vec(iack_vec), .xfer_ack(xfer_ack)
  );

  // cycle model built from the requirements
  int   m_cnt;
  logic m_armed, m_pend, m_xack, m_sticky, m_esc;
  logic [7:0] m_vec;

  function automatic int period(input logic [1:0] s);
    return 1 << (4 + 2 * int'(s));
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 4'h1) return {6'd0, m_esc, m_sticky};
    if (a == 4'h2) return m_vec;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_armed <= 1'b0; m_pend <= 1'b0; m_xack <= 1'b0;
      m_sticky <= 1'b0; m_esc <= 1'b0; m_vec <= 8'h0F;
    end else begin
      logic svc, hit, done, ack, rs, tk, fire, wok;
      wok  = reg_wr && reg_sup;
      svc  = wok && reg_addr == 4'h3;
      hit  = svc && reg_wdata == 8'hAA && m_armed;
      done = hit && !m_pend;
      ack  = iack && m_pend;
      rs   = done || ack;
      tk   = run_en && !rs && (m_cnt >= period(tmo_sel) - 1);
      fire = tk && m_pend && m_esc;
      if (tk) m_armed <= 1'b0;
      else if (svc && reg_wdata == 8'h55) m_armed <= 1'b1;
      else if (hit) m_armed <= 1'b0;
      if (rs) m_cnt <= 0;
      else if (run_en) m_cnt <= (m_cnt >= period(tmo_sel) - 1) ? 0 : m_cnt + 1;
      if (ack) m_pend <= 1'b0; else if (tk) m_pend <= 1'b1;
      m_xack <= fire;
      if (fire) m_sticky <= 1'b1;
      else if (wok && reg_addr == 4'h1 && reg_wdata[0]) m_sticky <= 1'b0;
      if (wok && reg_addr == 4'h1) m_esc <= reg_wdata[1];
      if (wok && reg_addr == 4'h2) m_vec <= reg_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R2/R5 irq", int'(irq), int'(m_pend));
    chk("R8 xfer_ack", int'(xfer_ack), int'(m_xack));
    chk("R6 iack_vec", int'(iack_vec), iack ? int'(m_vec) : 0);
    chk("R7/R9 rdata", int'(reg_rdata), int'(exp_rd(reg_addr)));
  endtask

  task automatic step(input logic w, input logic s, input logic [3:0] a,
                      input logic [7:0] d, input logic ia);
    reg_wr = w; reg_sup = s; reg_addr = a; reg_wdata = d; iack = ia;
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 4'h0, 8'h00, 1'b0);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_addr = 4'h2; #1;
    chk("R1 vec reset", int'(reg_rdata), 8'h0F);
    reg_addr = 4'h1; #1;
    chk("R1 ctrl reset", int'(reg_rdata), 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 xfer_ack reset", int'(xfer_ack), 0);
    run_en = 1'b1; tmo_sel = 2'd0;
    // R2 timeout after 16 edges
    idle(15); chk("R2 before", int'(irq), 0);
    idle(1);  chk("R2 at period", int'(irq), 1);
    // R5 key cannot cancel, iack can
    step(1, 1, 4'h3, 8'h55, 0); step(1, 1, 4'h3, 8'hAA, 0);
    chk("R5 key keeps irq", int'(irq), 1);
    step(0, 1, 4'h0, 8'h00, 1);
    chk("R6 default vector", int'(iack_vec), 8'h0F);
    chk("R5 iack clears", int'(irq), 0);
    // R4 lone 0xAA ignored
    step(1, 1, 4'h3, 8'hAA, 0); idle(14);
    chk("R4 before", int'(irq), 0);
    idle(1); chk("R4 lone fire ignored", int'(irq), 1);
    step(0, 1, 4'h0, 8'h00, 1);
    // R3 split key with other accesses
    step(1, 1, 4'h3, 8'h55, 0); step(1, 1, 4'h2, 8'h3C, 0);
    step(1, 1, 4'h3, 8'h12, 0); step(1, 1, 4'h3, 8'hAA, 0);
    idle(15); chk("R3 restarted", int'(irq), 0);
    idle(1);  chk("R3 full period", int'(irq), 1);
    // R7 user write ignored
    step(1, 0, 4'h2, 8'h99, 0); step(0, 1, 4'h2, 8'h00, 0);
    chk("R7 vec kept", int'(reg_rdata), 8'h3C);
    step(0, 1, 4'h0, 8'h00, 1);
    chk("R6 programmed vector", int'(iack_vec), 8'h3C);
    // R10 hold while disabled
    run_en = 1'b0; idle(40); chk("R10 held", int'(irq), 0);
    run_en = 1'b1; idle(15); chk("R10 resume", int'(irq), 0);
    idle(1); chk("R10 timeout", int'(irq), 1);
    // R8 escalation
    step(1, 1, 4'h1, 8'h02, 0); idle(14);
    chk("R8 before", int'(xfer_ack), 0);
    idle(1); chk("R8 pulse", int'(xfer_ack), 1);
    step(0, 1, 4'h1, 8'h00, 0);
    chk("R8 one cycle", int'(xfer_ack), 0);
    chk("R8 sticky", int'(reg_rdata), 8'h03);
    // R9 write-one-to-clear
    step(1, 1, 4'h1, 8'h02, 0); step(0, 1, 4'h1, 8'h00, 0);
    chk("R9 zero keeps", int'(reg_rdata), 8'h03);
    step(1, 1, 4'h1, 8'h03, 0); step(0, 1, 4'h1, 8'h00, 0);
    chk("R9 cleared", int'(reg_rdata), 8'h02);
    // R11 iack restarts timeout and escalation spacing
    step(0, 1, 4'h0, 8'h00, 1);
    idle(15); chk("R11 no early irq", int'(irq), 0);
    idle(1);  chk("R11 irq", int'(irq), 1);
    idle(15); chk("R11 no early xfer", int'(xfer_ack), 0);
    idle(1);  chk("R11 xfer", int'(xfer_ack), 1);
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic w, s, ia;
      logic [3:0] a;
      logic [7:0] d;
      int r;
      r  = $urandom_range(0, 99);
      w  = (r < 30);
      s  = ($urandom_range(0, 9) != 0);
      a  = 4'($urandom_range(0, 4));
      r  = $urandom_range(0, 3);
      d  = (r == 0) ? 8'h55 : (r == 1) ? 8'hAA : 8'($urandom_range(0, 255));
      ia = ($urandom_range(0, 39) == 0);
      run_en = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 299) == 0) tmo_sel = 2'($urandom_range(0, 1));
      step(w, s, a, d, ia);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule